// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a synchronous request port to an external asynchronous static RAM of 256K words of 16 bits. A client offers one request at a time with a valid/ready handshake. A request is either a read or a write, and carries an 18-bit word address and, for writes, 16 bits of data. The read word comes back on a response port with a one-cycle valid strobe. On the memory side the block drives the address lines, an active-low chip select, an active-low write strobe and an active-low output enable. The 16-bit data bus is split into an input, an output and an output-enable, so the pad cell that forms the tri-state buffer sits outside the block.

Reads are pipelined. A new read address can go out on every clock, and the word for each address is captured on the edge after that address was driven. A write holds its address steady for the whole write strobe and produces exactly one strobe pulse. A parameter chooses between two write timings:

- **Three-cycle write:** every line changes on the rising edge.
- **Two-cycle write:** the strobe is launched from the falling edge. This leaves half a clock of address setup before the strobe and half a clock of hold after it.

Every write is followed by one cycle in which the data-bus driver is off, before output enable can be asserted again.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset, chip select, write strobe and output enable are high, the data-bus enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read accepted on rising edge k shows its address from edge k, with chip select low, output enable low and write strobe high. On edge k+1 the word on `mem_dq_i` is captured, and it appears on `rsp_rdata` with `rsp_valid` high for one cycle.
- R3: `req_ready` stays high while reads are in flight, so consecutive reads are accepted on consecutive rising edges.
- R4: With `WR_TWO_CYCLE` = 0, a write keeps `req_ready` low for exactly three cycles after acceptance. The write strobe is low only in the second of those cycles, and it changes on rising edges only.
- R5: With `WR_TWO_CYCLE` = 1, a write keeps `req_ready` low for exactly two cycles. The write strobe falls on the falling edge inside the first cycle and rises on the falling edge inside the second.
- R6: While the write strobe is low, chip select is low and the address does not change.
- R7: The data-bus enable is high and the written word is stable on `mem_dq_o` from before the write strobe rises until after it has risen.
- R8: The data bus is never driven while output enable is low.
- R9: Output enable is asserted only after a cycle in which the data-bus enable was low. A read that follows a write therefore sees the driver released first.
- R10: Chip select is high whenever no request is in progress.
- R11: Each accepted write gives exactly one write-strobe pulse, and no strobe pulse occurs outside a write.
- R12: A read returns the word most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read word valid, one cycle |
| rsp_rdata | output | 16 | Read word |
| mem_addr | output | 18 | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_i | input | 16 | Data bus, memory to controller |
| mem_dq_o | output | 16 | Data bus, controller to memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The assertions assume that reset is held across at least one falling edge, so that the falling-edge strobe flop starts high. They also assume the memory answers a read within one clock. The stimulus changes request fields only on falling edges and holds each request until it is taken. It mixes read and write traffic over a small address pool that includes the lowest and highest addresses. The bench memory model answers reads combinationally and stores a word on the rising edge of the combined strobe. It flags any address movement inside a strobe and any strobe end with the bus undriven.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_W1,
    ST_W2,
    ST_W3,
    ST_TURN
  } ctl_state_e;

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter bit WR_TWO_CYCLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_cycle,
  output logic              we_low_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  ctl_state_e st_q, st_d;
  logic       accept;

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_RD) || (st_q == ST_TURN);
  assign accept    = req_valid && req_ready;
  assign rd_cycle  = (st_q == ST_RD);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_RD, ST_TURN:
        st_d = accept ? (req_write ? ST_W1 : ST_RD) : ST_IDLE;
      ST_W1:   st_d = ST_W2;
      ST_W2:   st_d = WR_TWO_CYCLE ? ST_TURN : ST_W3;
      ST_W3:   st_d = ST_TURN;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobe request: sampled on a falling edge in the short mode, on a rising edge otherwise
  generate
    if (WR_TWO_CYCLE) begin : g_req_fall
      assign we_low_req = (st_q == ST_W1);
    end else begin : g_req_rise
      assign we_low_req = (st_d == ST_W2);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) mem_addr <= req_addr;
      if (accept && req_write) mem_dq_o <= req_wdata;
      mem_ce_n  <= !((st_d == ST_RD) || (st_d == ST_W1) || (st_d == ST_W2) || (st_d == ST_W3));
      mem_oe_n  <= (st_d != ST_RD);
      mem_dq_oe <= (st_d == ST_W2) || (st_d == ST_W3);
    end
  end

  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  assert_idle_deselect_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> mem_ce_n);

endmodule

// File: rtl/asram_we_gen.sv
module asram_we_gen #(
  parameter bit WR_TWO_CYCLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic we_low_req,
  output logic mem_we_n
);

  logic we_q;

  generate
    if (WR_TWO_CYCLE) begin : g_fall_edge
      always_ff @(negedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= !we_low_req;
      end
    end else begin : g_rise_edge
      always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= !we_low_req;
      end
    end
  endgenerate

  assign mem_we_n = we_q;

endmodule

// File: rtl/asram_rd_cap.sv
module asram_rd_cap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_cycle,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_cycle;
      if (rd_cycle) rsp_rdata <= mem_dq_i;
    end
  end

  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_cycle));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter bit WR_TWO_CYCLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  logic rd_cycle;
  logic we_low_req;

  asram_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_TWO_CYCLE(WR_TWO_CYCLE)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_cycle(rd_cycle), .we_low_req(we_low_req),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

  asram_we_gen #(.WR_TWO_CYCLE(WR_TWO_CYCLE)) u_we (
    .clk(clk), .rst(rst), .we_low_req(we_low_req), .mem_we_n(mem_we_n)
  );

  asram_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .rd_cycle(rd_cycle), .mem_dq_i(mem_dq_i),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> $stable(mem_addr));

  assert_select_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  assert_data_through_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> (mem_dq_oe && $stable(mem_dq_o)));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> mem_we_n);

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_lane #(
  parameter bit TWO = 1'b0,
  parameter int P   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic done
);

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int last_acc = 0;

  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] mem_dq_i, mem_dq_o;

  asram_ctrl #(.ADDR_W(18), .DATA_W(16), .WR_TWO_CYCLE(TWO)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (mode %0d) t=%0t act=%0h exp=%0h", tag, TWO, $time, act, exp);
    end
  endtask

  // memory model: combinational read, store when the combined strobe ends
  logic [15:0] ram [logic [17:0]];
  wire wstb = mem_we_n | mem_ce_n;

  always @(posedge wstb) begin
    if (!rst) begin
      check(mem_dq_oe, "R7 bus driven at strobe end", {31'd0, mem_dq_oe}, 32'd1);
      ram[mem_addr] = mem_dq_o;
    end
  end

  always @(mem_addr) begin
    if (!rst && !wstb) check(1'b0, "R6 address moved under strobe", {14'd0, mem_addr}, 32'd0);
  end

  always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_i = ram.exists(mem_addr) ? ram[mem_addr] : 16'h0000;
    else
      mem_dq_i = 16'hFFFF;
  end

  // scoreboard
  logic [15:0] sb [logic [17:0]];
  logic [15:0] expq [$];

  always @(posedge clk) cyc++;

  task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (w) sb[a] = d;
    else expq.push_back(sb.exists(a) ? sb[a] : 16'h0000);
    last_acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && go && rsp_valid) begin
      if (expq.size() == 0) check(1'b0, "R12 unexpected response", {16'd0, rsp_rdata}, 32'd0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        check(rsp_rdata == e, "R12 read data", {16'd0, rsp_rdata}, {16'd0, e});
      end
    end
  end

  // quarter-cycle monitor after each rising edge
  int   run = 0, we_lows = 0, we_pos = 0;
  logic prev_dq_oe = 1'b0, prev_oe_n = 1'b1;
  always @(posedge clk) begin
    #(P/4);
    if (!rst && go) begin
      if (mem_dq_oe) check(mem_oe_n, "R8 drive while output enabled", {31'd0, mem_oe_n}, 32'd1);
      if (!mem_oe_n && prev_oe_n) check(!prev_dq_oe, "R9 turnaround", {31'd0, prev_dq_oe}, 32'd0);
      if (!mem_we_n) check(!mem_ce_n, "R6 select under strobe", {31'd0, mem_ce_n}, 32'd0);
      if (!req_ready) begin
        run++;
        if (!mem_we_n) begin we_lows++; we_pos = run; end
      end else if (run > 0) begin
        check(run == (TWO ? 2 : 3), TWO ? "R5 busy length" : "R4 busy length", run, TWO ? 2 : 3);
        check(we_lows == 1, "R11 pulses per write", we_lows, 1);
        check(we_pos == 2, TWO ? "R5 strobe position" : "R4 strobe position", we_pos, 2);
        run = 0; we_lows = 0; we_pos = 0;
      end else if (!mem_we_n) begin
        check(1'b0, "R11 strobe outside write", 0, 1);
      end
      prev_dq_oe = mem_dq_oe;
      prev_oe_n  = mem_oe_n;
    end
  end

  // three-quarter monitor: strobe level between falling and rising edge
  always @(negedge clk) begin
    #(P/4);
    if (!rst && go && !req_ready) begin
      if (run == 1)
        check(mem_we_n == !TWO, TWO ? "R5 strobe fell at falling edge" : "R4 strobe waits for rising edge",
              {31'd0, mem_we_n}, {31'd0, !TWO});
      if (run == 2)
        check(mem_we_n == TWO, TWO ? "R5 strobe rose at falling edge" : "R4 strobe low in second cycle",
              {31'd0, mem_we_n}, {31'd0, TWO});
    end
  end

  function automatic logic [17:0] pool(input logic [3:0] k);
    if (k == 4'd0) return 18'h00000;
    if (k == 4'd15) return 18'h3FFFF;
    return 18'(k * 18'h0451F);
  endfunction

  initial begin
    int acc [8];
    done = 1'b0;
    wait (go);
    @(negedge clk);
    // R1 reset state
    check(mem_ce_n, "R1 chip select", {31'd0, mem_ce_n}, 1);
    check(mem_we_n, "R1 write strobe", {31'd0, mem_we_n}, 1);
    check(mem_oe_n, "R1 output enable", {31'd0, mem_oe_n}, 1);
    check(!mem_dq_oe, "R1 bus released", {31'd0, mem_dq_oe}, 0);
    check(req_ready, "R1 ready", {31'd0, req_ready}, 1);
    check(!rsp_valid, "R1 no response", {31'd0, rsp_valid}, 0);

    // top address write, idle, then timed read (R2, R10)
    issue(1'b1, 18'h3FFFF, 16'hA5C3);
    repeat (5) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R10 idle lines",
          {28'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'hE);
    issue(1'b0, 18'h3FFFF, 16'h0);
    check(mem_addr == 18'h3FFFF, "R2 address driven", {14'd0, mem_addr}, 32'h3FFFF);
    check(!mem_ce_n && !mem_oe_n && mem_we_n, "R2 read controls",
          {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'h1);
    check(!rsp_valid, "R2 no early response", {31'd0, rsp_valid}, 0);
    @(negedge clk);
    check(rsp_valid, "R2 response strobe", {31'd0, rsp_valid}, 1);
    check(rsp_rdata == 16'hA5C3, "R2 response data", {16'd0, rsp_rdata}, 32'hA5C3);
    @(negedge clk);
    check(!rsp_valid, "R2 strobe one cycle", {31'd0, rsp_valid}, 0);

    // back-to-back reads (R3)
    for (int i = 0; i < 8; i++) issue(1'b1, 18'(i), 16'(16'h1000 + i));
    for (int i = 0; i < 8; i++) begin
      issue(1'b0, 18'(i), 16'h0);
      acc[i] = last_acc;
    end
    for (int i = 1; i < 8; i++)
      check(acc[i] - acc[i-1] == 1, "R3 one read per clock", acc[i] - acc[i-1], 1);

    // read right after write to the same word (R9, R12)
    issue(1'b1, 18'h00123, 16'hBEEF);
    issue(1'b0, 18'h00123, 16'h0);
    issue(1'b1, 18'h00000, 16'h5A5A);
    issue(1'b1, 18'h00000, 16'h0F0F);
    issue(1'b0, 18'h00000, 16'h0);

    // constrained random mix
    void'($urandom(TWO ? 32'd77 : 32'd91));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[1:0] == 2'b00) repeat (int'(r[3:2])) @(negedge clk);
      issue(r[4], pool(r[11:8]), r[31:16]);
    end

    repeat (8) @(negedge clk);
    check(expq.size() == 0, "R12 all reads answered", expq.size(), 0);
    check(mem_ce_n && !mem_dq_oe, "R10 deselected after traffic", {30'd0, mem_ce_n, mem_dq_oe}, 32'h2);
    done = 1'b1;
  end

endmodule

module sim_asram_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go  = 1'b0;
  logic done_a, done_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  sim_lane #(.TWO(1'b0), .P(CLK_PERIOD)) lane_three (.clk(clk), .rst(rst), .go(go), .done(done_a));
  sim_lane #(.TWO(1'b1), .P(CLK_PERIOD)) lane_two   (.clk(clk), .rst(rst), .go(go), .done(done_b));

  initial begin
    int c = 0;
    int errs;
    int chks;
    int wd = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    go = 1'b1;
    while (!(done_a && done_b) && c < 100000) begin
      @(posedge clk);
      c++;
    end
    if (!(done_a && done_b)) begin
      wd = 1;
      $display("FAIL watchdog expired");
    end
    errs = lane_three.n_err + lane_two.n_err + wd;
    chks = lane_three.n_chk + lane_two.n_chk + wd;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule